// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block keeps a four-bank DDR SDRAM refreshed on time. A free-running interval timer counts system clocks and, each time it runs out, adds one owed refresh to a small backlog. While the backlog is non-empty the block asks a command arbiter for the bus. The arbiter may hold the request off while it finishes its own traffic. Once the backlog reaches its limit, the request is flagged urgent and the arbiter is expected to grant it at once. After a grant the block asks for all banks to be precharged. When the banks report idle, it issues one auto-refresh and then blocks activates and further refreshes for the refresh cycle time.

The block also runs self-refresh. A level request from the power manager makes the block precharge all banks and then drop the clock-enable output. The backlog is cleared and the interval timer is frozen while the device refreshes itself. When the request drops, clock enable returns. The block then grants permission for non-read commands and for reads separately, after two different exit delays. The interval timer restarts from a full period. All timings are parameters counted in clock cycles.

Top module: `ddr_refresh_sched`

## Requirements
- R1: While reset is held and right after it is released, `cke`=1, `backlog`=0, `ref_req`=0, `ref_urgent`=0, `pre_all_req`=0, `ref_cmd`=0, `act_ok`=1 and `rd_ok`=1.
- R2: Outside self-refresh the interval timer expires once every `INTERVAL_CYC` clocks. The first expiry makes `backlog` read 1 exactly `INTERVAL_CYC` rising edges after reset is released. Each expiry adds one to `backlog`, and each issued refresh removes one.
- R3: `backlog` never exceeds `MAX_BACKLOG`. An expiry that arrives at the limit with no refresh issued in the same cycle is dropped. `ref_urgent` is 1 exactly when `ref_req` is 1 and `backlog` equals `MAX_BACKLOG`.
- R4: `ref_req` is 1 when the block is idle, `backlog` is non-zero, no lockout is running and `sr_req` is 0. A cycle with `ref_req` and `ref_gnt` both high moves the block to precharge: `pre_all_req`=1 and `ref_req`=0 until `banks_idle` is seen. In that cycle `ref_cmd` is 1 (combinational on `banks_idle`), and the refresh is counted.
- R5: After the edge that takes a `ref_cmd`, `act_ok` and `ref_req` stay 0 for the next `RFC_CYC`-1 cycles. Both may return in the `RFC_CYC`-th cycle.
- R6: With `sr_req`=1 in the idle state and no lockout running, the block raises `pre_all_req`. On `banks_idle` it drives `cke` to 0 from the next cycle and clears `backlog`. While `cke` is 0: `ref_req`, `ref_cmd`, `act_ok` and `rd_ok` are all 0, and `backlog` stays 0.
- R7: When `sr_req` falls during self-refresh, `cke` is 1 from the next cycle. Counting the first cycle with `cke` high as cycle 0, `act_ok` first rises in cycle `XSNR_CYC` and `rd_ok` first rises in cycle `XSRD_CYC`.
- R8: Self-refresh entry takes priority over a pending refresh. While `sr_req` is 1, `ref_req` stays 0 whatever the backlog.
- R9: The interval timer restarts on self-refresh exit. The next increment of `backlog` lands exactly `INTERVAL_CYC` edges after the exit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sr_req | input | 1 | Level request to stay in self-refresh |
| ref_gnt | input | 1 | Arbiter grant for a pending refresh request |
| banks_idle | input | 1 | All banks precharged and idle |
| ref_req | output | 1 | Refresh wanted; the arbiter may postpone it |
| ref_urgent | output | 1 | Refresh request at full backlog; must be granted |
| pre_all_req | output | 1 | Ask the arbiter to precharge every bank |
| ref_cmd | output | 1 | Issue one auto-refresh command this cycle |
| cke | output | 1 | Clock enable to the devices; 0 in self-refresh |
| act_ok | output | 1 | Activate and other non-read commands allowed |
| rd_ok | output | 1 | Read commands allowed |
| backlog | output | BL_W | Number of refreshes currently owed |

## Verification
`ref_req`, `pre_all_req`, `act_ok`, `rd_ok` and `cke` are decoded from registered state, so each moves one rising edge after the input that causes it. `ref_cmd` follows `banks_idle` in the same cycle. Backlog increments land on the edge that ends the `INTERVAL_CYC`-th cycle of a period. The lockouts run `RFC_CYC`, `XSNR_CYC` and `XSRD_CYC` cycles from the causing edge. The bench drives inputs at the falling edge and samples one time step later, so combinational responses are settled. It keeps its own counts of edges since the last refresh and since clock enable rose. It also keeps a backlog model stepped once per edge. Directed checks sample the cycle just before and the cycle at each boundary. Random arbiter behaviour is then checked against the same edge counts on every cycle.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REF_PREP = 2'd1,
        ST_SR_PREP  = 2'd2,
        ST_SR       = 2'd3
    } refsch_state_e;

    // One-cycle events produced by the controller and consumed by counters.
    typedef struct packed {
        logic ref_issue;
        logic sr_enter;
        logic sr_exit;
        logic in_sr;
    } refsch_evt_t;

    // Bits needed to hold values 0..v.
    function automatic int unsigned cnt_w(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/refsch_interval.sv
module refsch_interval
    import refsch_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1040,
    parameter int unsigned MAX_BACKLOG  = 8,
    parameter int unsigned BL_W         = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  refsch_evt_t     evt,
    output logic [BL_W-1:0] backlog
);
    localparam int unsigned IW = cnt_w(INTERVAL_CYC - 1);
    localparam logic [IW-1:0]   RELOAD = IW'(INTERVAL_CYC - 1);
    localparam logic [BL_W-1:0] LIMIT  = BL_W'(MAX_BACKLOG);

    logic [IW-1:0] tick_cnt;
    logic          expire;
    logic          at_limit;
    logic          add_one;

    assign expire   = !evt.in_sr && (tick_cnt == '0);
    assign at_limit = (backlog == LIMIT);
    assign add_one  = expire && !(at_limit && !evt.ref_issue);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= RELOAD;
        end else if (evt.sr_exit) begin
            tick_cnt <= RELOAD;
        end else if (!evt.in_sr) begin
            tick_cnt <= expire ? RELOAD : tick_cnt - IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || evt.sr_enter) begin
            backlog <= '0;
        end else begin
            backlog <= backlog + BL_W'(add_one) - BL_W'(evt.ref_issue);
        end
    end

endmodule

// File: rtl/refsch_holdoff.sv
module refsch_holdoff
    import refsch_pkg::*;
#(
    parameter int unsigned LOAD_VAL = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int unsigned W = cnt_w(LOAD_VAL);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= W'(LOAD_VAL);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/refsch_ctrl.sv
module refsch_ctrl
    import refsch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sr_req,
    input  logic        ref_gnt,
    input  logic        banks_idle,
    input  logic        have_work,
    input  logic        hold_rfc,
    input  logic        hold_xsnr,
    input  logic        hold_xsrd,
    output logic        ref_req,
    output logic        pre_all_req,
    output logic        act_ok,
    output logic        rd_ok,
    output logic        cke,
    output refsch_evt_t evt
);
    refsch_state_e state, state_nx;
    logic          ready;

    assign ready = !hold_rfc && !hold_xsnr;

    always_comb begin
        ref_req       = (state == ST_IDLE) && have_work && ready && !sr_req;
        pre_all_req   = (state == ST_REF_PREP) || (state == ST_SR_PREP);
        evt.ref_issue = (state == ST_REF_PREP) && banks_idle;
        evt.sr_enter  = (state == ST_SR_PREP) && banks_idle;
        evt.sr_exit   = (state == ST_SR) && !sr_req;
        evt.in_sr     = (state == ST_SR);
        act_ok        = (state == ST_IDLE) && ready;
        rd_ok         = act_ok && !hold_xsrd;
        cke           = (state != ST_SR);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sr_req && ready) begin
                    state_nx = ST_SR_PREP;
                end else if (ref_req && ref_gnt) begin
                    state_nx = ST_REF_PREP;
                end
            end
            ST_REF_PREP: if (banks_idle) state_nx = ST_IDLE;
            ST_SR_PREP:  if (banks_idle) state_nx = ST_SR;
            ST_SR:       if (!sr_req)    state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
    import refsch_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1040,
    parameter int unsigned MAX_BACKLOG  = 8,
    parameter int unsigned RFC_CYC      = 10,
    parameter int unsigned XSNR_CYC     = 10,
    parameter int unsigned XSRD_CYC     = 200,
    localparam int unsigned BL_W        = cnt_w(MAX_BACKLOG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sr_req,
    input  logic            ref_gnt,
    input  logic            banks_idle,
    output logic            ref_req,
    output logic            ref_urgent,
    output logic            pre_all_req,
    output logic            ref_cmd,
    output logic            cke,
    output logic            act_ok,
    output logic            rd_ok,
    output logic [BL_W-1:0] backlog
);
    localparam int unsigned NHOLD = 3;
    localparam int unsigned HOLD_LOAD [NHOLD] = '{RFC_CYC - 1, XSNR_CYC, XSRD_CYC};

    refsch_evt_t      evt;
    logic [NHOLD-1:0] hold_ld;
    logic [NHOLD-1:0] hold_busy;

    assign hold_ld = {evt.sr_exit, evt.sr_exit, evt.ref_issue};

    for (genvar gi = 0; gi < NHOLD; gi++) begin : g_hold
        refsch_holdoff #(.LOAD_VAL(HOLD_LOAD[gi])) u_hold (
            .clk  (clk),
            .rst  (rst),
            .load (hold_ld[gi]),
            .busy (hold_busy[gi])
        );
    end

    refsch_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sr_req      (sr_req),
        .ref_gnt     (ref_gnt),
        .banks_idle  (banks_idle),
        .have_work   (backlog != '0),
        .hold_rfc    (hold_busy[0]),
        .hold_xsnr   (hold_busy[1]),
        .hold_xsrd   (hold_busy[2]),
        .ref_req     (ref_req),
        .pre_all_req (pre_all_req),
        .act_ok      (act_ok),
        .rd_ok       (rd_ok),
        .cke         (cke),
        .evt         (evt)
    );

    refsch_interval #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .MAX_BACKLOG  (MAX_BACKLOG),
        .BL_W         (BL_W)
    ) u_interval (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .backlog (backlog)
    );

    assign ref_cmd    = evt.ref_issue;
    assign ref_urgent = ref_req && (backlog == BL_W'(MAX_BACKLOG));

endmodule

// File: rtl/refsch_checker.sv
module refsch_checker #(
    parameter int unsigned MAX_BACKLOG = 8,
    parameter int unsigned RFC_CYC     = 10,
    parameter int unsigned XSNR_CYC    = 10,
    parameter int unsigned XSRD_CYC    = 200,
    parameter int unsigned BL_W        = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            ref_req,
    input logic            ref_urgent,
    input logic            pre_all_req,
    input logic            ref_cmd,
    input logic            banks_idle,
    input logic            cke,
    input logic            act_ok,
    input logic            rd_ok,
    input logic [BL_W-1:0] backlog
);
    int unsigned since_ref;
    int unsigned since_cke;

    always_ff @(posedge clk) begin
        if (rst) since_ref <= RFC_CYC;
        else if (ref_cmd) since_ref <= 1;
        else if (since_ref < RFC_CYC) since_ref <= since_ref + 1;
    end

    always_ff @(posedge clk) begin
        if (rst) since_cke <= XSRD_CYC;
        else if (!cke) since_cke <= 0;
        else if (since_cke < XSRD_CYC) since_cke <= since_cke + 1;
    end

    AST_BACKLOG_LIMIT: assert property (@(posedge clk) disable iff (rst)
        backlog <= BL_W'(MAX_BACKLOG)); // R3
    AST_URGENT_REQ: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> ref_req); // R3
    AST_BACKLOG_STEP: assert property (@(posedge clk) disable iff (rst)
        (backlog > $past(backlog)) |-> (backlog == BL_W'($past(backlog) + 1'b1))); // R2
    AST_REF_IDLE_BANKS: assert property (@(posedge clk) disable iff (rst)
        ref_cmd |-> (banks_idle && pre_all_req)); // R4
    AST_RFC_SPACING: assert property (@(posedge clk) disable iff (rst)
        (ref_cmd || act_ok) |-> (since_ref >= RFC_CYC)); // R5
    AST_SR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (!ref_req && !ref_cmd && !act_ok && !rd_ok)); // R6
    AST_XSNR_WAIT: assert property (@(posedge clk) disable iff (rst)
        act_ok |-> (since_cke >= XSNR_CYC)); // R7
    AST_XSRD_WAIT: assert property (@(posedge clk) disable iff (rst)
        rd_ok |-> (since_cke >= XSRD_CYC)); // R7

endmodule

bind ddr_refresh_sched refsch_checker #(
    .MAX_BACKLOG (MAX_BACKLOG),
    .RFC_CYC     (RFC_CYC),
    .XSNR_CYC    (XSNR_CYC),
    .XSRD_CYC    (XSRD_CYC),
    .BL_W        (BL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_req     (ref_req),
    .ref_urgent  (ref_urgent),
    .pre_all_req (pre_all_req),
    .ref_cmd     (ref_cmd),
    .banks_idle  (banks_idle),
    .cke         (cke),
    .act_ok      (act_ok),
    .rd_ok       (rd_ok),
    .backlog     (backlog)
);

// File: tb/ddr_refresh_sched_test.sv
module ddr_refresh_sched_test;
    localparam int INTERVAL = 40;
    localparam int MAXB     = 8;
    localparam int RFC      = 6;
    localparam int XSNR     = 8;
    localparam int XSRD     = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sr_req = 1'b0;
    logic       ref_gnt = 1'b0;
    logic       banks_idle = 1'b0;
    logic       ref_req, ref_urgent, pre_all_req, ref_cmd, cke, act_ok, rd_ok;
    logic [3:0] backlog;

    int total = 0;
    int bad   = 0;

    // bench models
    int m_bl = 0;
    int m_ph = 0;
    int since_ref = RFC;
    int since_cke = XSRD;

    always #5 clk = ~clk;

    ddr_refresh_sched #(
        .INTERVAL_CYC (INTERVAL),
        .MAX_BACKLOG  (MAXB),
        .RFC_CYC      (RFC),
        .XSNR_CYC     (XSNR),
        .XSRD_CYC     (XSRD)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .sr_req      (sr_req),
        .ref_gnt     (ref_gnt),
        .banks_idle  (banks_idle),
        .ref_req     (ref_req),
        .ref_urgent  (ref_urgent),
        .pre_all_req (pre_all_req),
        .ref_cmd     (ref_cmd),
        .cke         (cke),
        .act_ok      (act_ok),
        .rd_ok       (rd_ok),
        .backlog     (backlog)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    // Expected backlog after one edge, from R2/R3/R6/R9.
    function automatic int next_backlog(input int bl, input int ph, input bit rc,
                                        input bit cke_pre, input bit cke_post);
        bit exp_tick;
        if (cke_pre && !cke_post) return 0;
        if (!cke_pre) return bl;
        exp_tick = (ph == INTERVAL - 1);
        if (exp_tick && !(bl == MAXB && !rc)) bl++;
        if (rc) bl--;
        return bl;
    endfunction

    // Called at a falling edge with inputs already set; returns at the next falling edge.
    task automatic step();
        bit cke_p, rc_p;
        #1;
        cke_p = cke;
        rc_p  = ref_cmd;
        chk(int'(backlog) <= MAXB, "R3 backlog bound", backlog, MAXB);
        if (act_ok) begin
            chk(since_ref >= RFC, "R5 act_ok vs refresh spacing", since_ref, RFC);
            chk(since_cke >= XSNR, "R7 act_ok vs non-read exit wait", since_cke, XSNR);
        end
        if (rd_ok) chk(since_cke >= XSRD, "R7 rd_ok vs read exit wait", since_cke, XSRD);
        if (ref_cmd) begin
            chk(banks_idle == 1'b1, "R4 refresh only with idle banks", banks_idle, 1);
            chk(since_ref >= RFC, "R5 refresh spacing", since_ref, RFC);
        end
        if (!cke) chk(!ref_req && !act_ok && !rd_ok, "R6 quiet in self-refresh",
                      {ref_req, act_ok, rd_ok}, 0);
        @(posedge clk);
        @(negedge clk);
        m_bl = next_backlog(m_bl, m_ph, rc_p, cke_p, cke);
        if (cke_p) m_ph = (m_ph == INTERVAL - 1) ? 0 : m_ph + 1;
        else if (cke) m_ph = 0;
        if (rc_p) since_ref = 1;
        else if (since_ref < RFC) since_ref++;
        if (!cke_p) since_cke = 0;
        else if (since_cke < XSRD) since_cke++;
        expect_eq("R2 backlog model", backlog, m_bl);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        expect_eq("R1 cke", cke, 1);
        expect_eq("R1 backlog", backlog, 0);
        expect_eq("R1 ref_req", ref_req, 0);
        expect_eq("R1 ref_urgent", ref_urgent, 0);
        expect_eq("R1 pre_all_req", pre_all_req, 0);
        expect_eq("R1 ref_cmd", ref_cmd, 0);
        expect_eq("R1 act_ok", act_ok, 1);
        expect_eq("R1 rd_ok", rd_ok, 1);

        // R2 first expiry timing
        steps(INTERVAL - 1);
        expect_eq("R2 before first expiry", backlog, 0);
        step();
        expect_eq("R2 first expiry", backlog, 1);
        expect_eq("R4 request with backlog", ref_req, 1);
        expect_eq("R3 not urgent below limit", ref_urgent, 0);

        // R3 saturation with postponed refreshes
        steps(7 * INTERVAL);
        expect_eq("R3 reaches limit", backlog, MAXB);
        expect_eq("R3 urgent at limit", ref_urgent, 1);
        steps(2 * INTERVAL);
        expect_eq("R3 saturated", backlog, MAXB);

        // R4 grant, precharge-all, issue
        ref_gnt = 1'b1;
        banks_idle = 1'b0;
        step();
        ref_gnt = 1'b0;
        expect_eq("R4 precharge request", pre_all_req, 1);
        expect_eq("R4 request dropped", ref_req, 0);
        steps(2);
        expect_eq("R4 waits for idle banks", pre_all_req, 1);
        expect_eq("R4 no refresh before idle", ref_cmd, 0);
        banks_idle = 1'b1;
        #1;
        expect_eq("R4 refresh on idle banks", ref_cmd, 1);
        step();
        banks_idle = 1'b0;
        expect_eq("R5 lockout first cycle", act_ok, 0);
        steps(RFC - 2);
        expect_eq("R5 lockout last cycle act", act_ok, 0);
        expect_eq("R5 lockout last cycle req", ref_req, 0);
        step();
        expect_eq("R5 lockout over act", act_ok, 1);
        expect_eq("R5 lockout over req", ref_req, 1);

        // R6/R8 self-refresh entry with backlog pending
        sr_req = 1'b1;
        #1;
        expect_eq("R8 no request while sr_req", ref_req, 0);
        step();
        expect_eq("R6 precharge before self-refresh", pre_all_req, 1);
        expect_eq("R8 self-refresh first", ref_req, 0);
        expect_eq("R6 cke still high", cke, 1);
        banks_idle = 1'b1;
        step();
        banks_idle = 1'b0;
        expect_eq("R6 cke low", cke, 0);
        expect_eq("R6 backlog cleared", backlog, 0);
        expect_eq("R6 act_ok low", act_ok, 0);
        expect_eq("R6 rd_ok low", rd_ok, 0);
        steps(3 * INTERVAL);
        expect_eq("R6 timer frozen", backlog, 0);
        expect_eq("R6 cke held low", cke, 0);

        // R7 exit delays
        sr_req = 1'b0;
        step();
        expect_eq("R7 cke back", cke, 1);
        expect_eq("R7 act_ok not yet", act_ok, 0);
        steps(XSNR - 1);
        expect_eq("R7 act_ok one before", act_ok, 0);
        step();
        expect_eq("R7 act_ok at non-read wait", act_ok, 1);
        expect_eq("R7 rd_ok still low", rd_ok, 0);
        steps(XSRD - XSNR - 1);
        expect_eq("R7 rd_ok one before", rd_ok, 0);
        step();
        expect_eq("R7 rd_ok at read wait", rd_ok, 1);

        // R9 interval restarts at exit
        steps(INTERVAL - 1 - XSRD);
        expect_eq("R9 before restarted expiry", backlog, 0);
        step();
        expect_eq("R9 restarted expiry", backlog, 1);

        // random arbiter and power-manager behaviour
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 500 == 0) sr_req = ~sr_req;
            banks_idle = ($urandom % 3) != 0;
            #1;
            ref_gnt = ref_urgent || (ref_req && ($urandom % 5 == 0));
            step();
        end
        ref_gnt = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule